// File: doc/BRIEF.md
# Byte/Word Arithmetic Status Flag Unit

This block performs one of four arithmetic operations (add, subtract, increment, decrement) on either 8-bit or 16-bit operands. It registers the result and derives the six arithmetic status flags from it: carry, parity, auxiliary carry, zero, sign and overflow. The same 16-bit status word also holds three control flags (single-step trap, interrupt enable and string direction). Software-visible logic elsewhere sets or clears these flags through explicit command inputs.

Every update is committed on a rising clock edge on which the update enable is high. The registered result and the status word are visible from that edge onward, so the latency is one cycle. When the enable is low, the result, the status word and all commands are frozen or ignored. A downstream datapath reads the status word as a whole. Its bit layout is fixed because conditional logic decodes it by position.

Top module: `flagword_unit`

## Requirements
- R1: A synchronous reset sets `status` to 16'h0002 and `result` to 0.
- R2: The `status` bit positions are as follows: carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt-enable bit 9, direction bit 10 and overflow bit 11. Bit 1 always reads 1. Bits 3, 5 and 15:12 always read 0.
- R3: `op_sel` selects the operation: 2'b00 computes a+b, 2'b01 computes a-b, 2'b10 computes a+1 and 2'b11 computes a-1. Increment and decrement ignore `opb`. With `wide`=0 only the low 8 bits of the operands are used, and `result[15:8]` reads 0.
- R4: Carry is set on a carry out of the top bit of the selected width for add and increment. For subtract it is set on a borrow into that bit, which means the unsigned a is less than b.
- R5: Increment and decrement leave carry at its previous value.
- R6: Auxiliary is set on a carry from bit 3 into bit 4 on an add. On a subtract it is set on a borrow from bit 4 into bit 3.
- R7: Zero is set when the result is all zeros at the selected width. Sign equals the top bit of the result at the selected width.
- R8: Parity is 1 when the low 8 bits of the result hold an even number of ones. This applies in word mode too.
- R9: Overflow is set when the signed result does not fit in the selected width.
- R10: While `upd_en` is low, `status` and `result` keep their values, and the operation inputs and control commands have no effect.
- R11: With `upd_en` high, each control flag is set by its set input and cleared by its clear input. Set wins if both inputs are high. Arithmetic operations never change the control flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Commit operation and commands this cycle |
| op_sel | input | 2 | Operation select (see R3) |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand (add/subtract only) |
| trap_set | input | 1 | Set trap flag |
| trap_clr | input | 1 | Clear trap flag |
| intr_set | input | 1 | Set interrupt-enable flag |
| intr_clr | input | 1 | Clear interrupt-enable flag |
| dir_set | input | 1 | Set direction flag (step downward) |
| dir_clr | input | 1 | Clear direction flag (step upward) |
| result | output | 16 | Registered result |
| status | output | 16 | Registered status word |

## Verification
The bench targets the following corner cases, each of which exposes a specific design error:
- **Width boundaries.** It runs 16'hFFFF+1 and 8'h7F+1. A unit that picks the carry or sign bit from the wrong width reports no carry or a wrong sign.
- **Byte-mode borrows.** It runs 0-1 in byte mode. A unit that takes the borrow from bit 16 misses it, and one that forgets to mask the upper byte leaks 1s into `result[15:8]`.
- **Increment after carry.** It increments right after an operation that set carry. A unit that lets increment write carry clears it.
- **Word parity.** It includes word results whose high byte would flip the parity of the whole word.
- **Gated commands.** It issues commands with the enable low, and issues set and clear together. These catch a unit that ignores the gating or resolves the conflict the wrong way.
- **Random sweep.** A sweep against an independent arithmetic model covers the remaining combinations.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    localparam int STW = 16;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } flag_op_e;

    localparam int POS_C = 0;
    localparam int POS_P = 2;
    localparam int POS_A = 4;
    localparam int POS_Z = 6;
    localparam int POS_S = 7;
    localparam int POS_T = 8;
    localparam int POS_I = 9;
    localparam int POS_D = 10;
    localparam int POS_O = 11;

    localparam logic [STW-1:0] STATUS_FIXED = 16'h0002;

    typedef struct packed {
        logic c;
        logic p;
        logic a;
        logic z;
        logic s;
        logic o;
    } arith_flags_t;

    typedef struct packed {
        logic t;
        logic i;
        logic d;
    } ctrl_flags_t;

    function automatic logic even_ones(input logic [7:0] v);
        return ~(^v);
    endfunction

    function automatic logic [STW-1:0] pack_status(input arith_flags_t af,
                                                   input ctrl_flags_t cf);
        logic [STW-1:0] w;
        w        = STATUS_FIXED;
        w[POS_C] = af.c;
        w[POS_P] = af.p;
        w[POS_A] = af.a;
        w[POS_Z] = af.z;
        w[POS_S] = af.s;
        w[POS_O] = af.o;
        w[POS_T] = cf.t;
        w[POS_I] = cf.i;
        w[POS_D] = cf.d;
        return w;
    endfunction

    function automatic logic next_ctrl(input logic cur, input logic set_c,
                                       input logic clr_c);
        return set_c ? 1'b1 : (clr_c ? 1'b0 : cur);
    endfunction

endpackage

// File: rtl/flagu_addsub.sv
module flagu_addsub
    import flagu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  flag_op_e           op,
    input  logic               wide,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  res,
    output logic               cout,
    output logic               aux,
    output logic               ovf
);
    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] am, bm;
    logic [DATA_W:0]   full;
    logic              is_sub, ta, tb, tr;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_DEC);
        am     = wide ? a : {{(DATA_W-HW){1'b0}}, a[HW-1:0]};
        if (op == OP_INC || op == OP_DEC)
            bm = {{(DATA_W-1){1'b0}}, 1'b1};
        else
            bm = wide ? b : {{(DATA_W-HW){1'b0}}, b[HW-1:0]};
        full = is_sub ? ({1'b0, am} - {1'b0, bm})
                      : ({1'b0, am} + {1'b0, bm});
        res  = wide ? full[DATA_W-1:0] : {{(DATA_W-HW){1'b0}}, full[HW-1:0]};
        cout = wide ? full[DATA_W] : full[HW];
        aux  = am[4] ^ bm[4] ^ full[4];
        ta   = wide ? am[DATA_W-1]   : am[HW-1];
        tb   = wide ? bm[DATA_W-1]   : bm[HW-1];
        tr   = wide ? full[DATA_W-1] : full[HW-1];
        ovf  = is_sub ? ((ta != tb) && (tr != ta))
                      : ((ta == tb) && (tr != ta));
    end
endmodule

// File: rtl/flagu_eval.sv
module flagu_eval
    import flagu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  flag_op_e          op,
    input  logic              wide,
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    input  logic              aux,
    input  logic              ovf,
    input  logic              prev_c,
    output arith_flags_t      nxt
);
    localparam int HW = DATA_W / 2;

    always_comb begin
        nxt.c = (op == OP_INC || op == OP_DEC) ? prev_c : cout;
        nxt.p = even_ones(res[7:0]);
        nxt.a = aux;
        nxt.z = wide ? (res == '0) : (res[HW-1:0] == '0);
        nxt.s = wide ? res[DATA_W-1] : res[HW-1];
        nxt.o = ovf;
    end
endmodule

// File: rtl/flagword_unit.sv
module flagword_unit
    import flagu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [1:0]        op_sel,
    input  logic              wide,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              trap_set,
    input  logic              trap_clr,
    input  logic              intr_set,
    input  logic              intr_clr,
    input  logic              dir_set,
    input  logic              dir_clr,
    output logic [DATA_W-1:0] result,
    output logic [STW-1:0]    status
);
    flag_op_e          op;
    logic [DATA_W-1:0] sum;
    logic              cout, aux, ovf;
    arith_flags_t      af_q, af_d;
    ctrl_flags_t       cf_q, cf_d;
    logic [DATA_W-1:0] res_q;

    assign op = flag_op_e'(op_sel);

    flagu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op(op), .wide(wide), .a(opa), .b(opb),
        .res(sum), .cout(cout), .aux(aux), .ovf(ovf)
    );

    flagu_eval #(.DATA_W(DATA_W)) u_eval (
        .op(op), .wide(wide), .res(sum), .cout(cout), .aux(aux),
        .ovf(ovf), .prev_c(af_q.c), .nxt(af_d)
    );

    always_comb begin
        cf_d.t = next_ctrl(cf_q.t, trap_set, trap_clr);
        cf_d.i = next_ctrl(cf_q.i, intr_set, intr_clr);
        cf_d.d = next_ctrl(cf_q.d, dir_set,  dir_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            af_q  <= '0;
            cf_q  <= '0;
            res_q <= '0;
        end else if (upd_en) begin
            af_q  <= af_d;
            cf_q  <= cf_d;
            res_q <= sum;
        end
    end

    assign result = res_q;
    assign status = pack_status(af_q, cf_q);
endmodule

// File: rtl/flagword_unit_chk.sv
module flagword_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_en,
    input logic [1:0]        op_sel,
    input logic              wide,
    input logic              dir_set,
    input logic [DATA_W-1:0] result,
    input logic [15:0]       status
);
    localparam int HW = DATA_W / 2;

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen && !rst)
            AST_RESET_STATE: assert (status == 16'h0002 && result == '0); // R1
    end

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> (status[1] && !status[3] && !status[5] && status[15:12] == 4'h0)); // R2

    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel[1]) |=> (status[0] == $past(status[0]))); // R5

    AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (status[6] == (result == '0)) &&
                   (status[7] == ($past(wide) ? result[DATA_W-1] : result[HW-1]))); // R7

    AST_PARITY_LOW: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (status[2] == ~(^result[7:0]))); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> ($stable(status) && $stable(result))); // R10

    AST_DIR_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_en && dir_set) |=> status[10]); // R11
endmodule

bind flagword_unit flagword_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_sel(op_sel), .wide(wide),
    .dir_set(dir_set), .result(result), .status(status)
);

// File: tb/flagword_unit_test.sv
`timescale 1ns/1ps
module flagword_unit_test;
    localparam real HALF = 4.0;

    logic        clk = 0;
    logic        rst = 1;
    logic        upd_en = 0;
    logic [1:0]  op_sel = 0;
    logic        wide = 0;
    logic [15:0] opa = 0, opb = 0;
    logic        trap_set = 0, trap_clr = 0, intr_set = 0, intr_clr = 0;
    logic        dir_set = 0, dir_clr = 0;
    logic [15:0] result, status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [15:0] m_status, m_result;

    always #(HALF) clk = ~clk;

    flagword_unit uut (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_sel(op_sel), .wide(wide),
        .opa(opa), .opb(opb), .trap_set(trap_set), .trap_clr(trap_clr),
        .intr_set(intr_set), .intr_clr(intr_clr), .dir_set(dir_set),
        .dir_clr(dir_clr), .result(result), .status(status)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    function automatic void model(input logic [1:0] op, input logic w,
                                  input logic [15:0] a, input logic [15:0] b,
                                  input logic [5:0] cmd);
        logic [31:0] mask, am, bm, s;
        int sa, sb, sr, lo, hi;
        logic c, ac, ov;
        logic [15:0] r, st;
        mask = w ? 32'hFFFF : 32'h00FF;
        am = {16'h0, a} & mask;
        bm = op[1] ? 32'd1 : ({16'h0, b} & mask);
        s  = op[0] ? (am - bm) : (am + bm);
        r  = 16'(s & mask);
        c  = op[0] ? (am < bm) : (s > mask);
        ac = op[0] ? ((am & 15) < (bm & 15)) : (((am & 15) + (bm & 15)) > 15);
        sa = w ? int'($signed(am[15:0])) : int'($signed(am[7:0]));
        sb = w ? int'($signed(bm[15:0])) : int'($signed(bm[7:0]));
        sr = op[0] ? sa - sb : sa + sb;
        lo = w ? -32768 : -128;
        hi = w ? 32767 : 127;
        ov = (sr < lo) || (sr > hi);
        st = 16'h0002;
        st[0]  = op[1] ? m_status[0] : c;
        st[2]  = ($countones(r[7:0]) % 2) == 0;
        st[4]  = ac;
        st[6]  = (r == 0);
        st[7]  = w ? r[15] : r[7];
        st[11] = ov;
        st[8]  = cmd[5] ? 1'b1 : cmd[4] ? 1'b0 : m_status[8];
        st[9]  = cmd[3] ? 1'b1 : cmd[2] ? 1'b0 : m_status[9];
        st[10] = cmd[1] ? 1'b1 : cmd[0] ? 1'b0 : m_status[10];
        m_status = st;
        m_result = r;
    endfunction

    // Drive at negedge, commit at next posedge, sample at following negedge.
    task automatic apply(input string tag, input logic en, input logic [1:0] op,
                         input logic w, input logic [15:0] a, input logic [15:0] b,
                         input logic [5:0] cmd);
        @(negedge clk);
        upd_en = en; op_sel = op; wide = w; opa = a; opb = b;
        {trap_set, trap_clr, intr_set, intr_clr, dir_set, dir_clr} = cmd;
        @(negedge clk);
        upd_en = 0;
        {trap_set, trap_clr, intr_set, intr_clr, dir_set, dir_clr} = '0;
        if (en) model(op, w, a, b, cmd);
        chk({tag, " status"}, status, m_status);
        chk({tag, " result"}, result, m_result);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_status = 16'h0002; m_result = 0;
        chk("R1 reset status", status, 16'h0002);
        chk("R1 reset result", result, 16'h0000);
        chk("R2 fixed bits", status & 16'hF02A, 16'h0002);
    endtask

    task automatic t_boundaries();
        apply("R4 word carry", 1, 2'b00, 1, 16'hFFFF, 16'h0001, 0);
        chk("R4 word FFFF+1", status, 16'h0057);
        apply("R9 byte ovf", 1, 2'b00, 0, 16'hAB7F, 16'hCD01, 0);
        chk("R9 byte 7F+1", status, 16'h0892);
        chk("R3 byte result", result, 16'h0080);
        apply("R4 byte borrow", 1, 2'b01, 0, 16'h5500, 16'h0001, 0);
        chk("R6 byte 0-1", status, 16'h0097);
        chk("R3 upper zero", result, 16'h00FF);
    endtask

    task automatic t_incdec();
        apply("R5 inc keeps carry", 1, 2'b10, 0, 16'h00FF, 16'h1234, 0);
        chk("R5 inc FF status", status, 16'h0057);
        apply("R3 inc ignores opb", 1, 2'b10, 1, 16'h0005, 16'hBEEF, 0);
        chk("R3 inc result", result, 16'h0006);
        apply("R7 add clears carry", 1, 2'b00, 1, 16'h0001, 16'h0001, 0);
        apply("R9 dec word ovf", 1, 2'b11, 1, 16'h8000, 16'h7777, 0);
        chk("R9 dec 8000", status, 16'h0816);
    endtask

    task automatic t_parity();
        apply("R8 word parity", 1, 2'b00, 1, 16'h0100, 16'h0000, 0);
        chk("R8 parity 0100", status, 16'h0006);
        apply("R8 word parity odd", 1, 2'b00, 1, 16'h0301, 16'h0000, 0);
        chk("R8 parity bit", status[2], 1'b0);
    endtask

    task automatic t_hold();
        logic [15:0] s0, r0;
        s0 = status; r0 = result;
        apply("R10 hold", 0, 2'b00, 1, 16'h1234, 16'h4321, 6'b101010);
        chk("R10 status held", status, s0);
        chk("R10 result held", result, r0);
    endtask

    task automatic t_ctrl();
        apply("R11 set all", 1, 2'b00, 0, 16'h0010, 16'h0020, 6'b101010);
        chk("R11 ctrl set", status & 16'h0700, 16'h0700);
        apply("R11 set wins", 1, 2'b11, 1, 16'h0000, 16'h0000, 6'b011100);
        chk("R11 T clr I kept", status & 16'h0700, 16'h0600);
        apply("R11 arith only", 1, 2'b01, 1, 16'h0000, 16'h0001, 0);
        chk("R11 ctrl unchanged", status & 16'h0700, 16'h0600);
        apply("R11 dir clr", 1, 2'b00, 0, 16'h0000, 16'h0000, 6'b000001);
        chk("R11 D cleared", status[10], 1'b0);
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            apply("R3/R4/R6/R9 sweep", 1'b1, lf[1:0], lf[2], lf[31:16],
                  {lf[15:3], lf[2:0] ^ lf[18:16]}, {lf[9:4]});
        end
    endtask

    initial begin
        t_reset();
        t_boundaries();
        t_incdec();
        t_parity();
        t_hold();
        t_ctrl();
        t_sweep();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule